// File: doc/BRIEF.md
# Short-Vector Register Index Sequencer

This block expands one floating-point short-vector operation into a run of element operations and supplies the register indices each element uses. A start pulse captures a destination index, one or two source indices, a stride-select bit, a double-width flag, an operand-form bit and a vector length. The block then presents one index triple per element on a valid/ready output stream, marking the first and final elements and tagging multi-element runs for delayed commit. The arithmetic, register-file access and instruction decoding happen elsewhere.

Indices do not advance linearly. Each index stays inside its own bank of eight registers. Only the offset within the bank advances, and it wraps modulo 8. A source index that lies in the scalar bank stays fixed while the other indices step. A run whose destination lies in the scalar bank is rejected with a one-cycle error pulse.

Output stream rules: an element is transferred on a rising clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output stays unchanged. A start is taken when `busy` is low. It is also taken in the cycle in which the final element of the current run is transferred. A start at any other time is ignored.

Top module: `svidx_seq`

## Requirements
- R1: After reset, `busy`, `out_valid` and `start_err` are all 0.
- R2: A legal start with length N (1 to 8) produces exactly N transfers. The first output appears in the cycle after the start. Element 0 carries the captured indices and `out_first`=1. Only the final element has `out_last`=1, and `busy` drops after that element is transferred.
- R3: The step size is 1 when `stride_sel`=0 and 2 when `stride_sel`=1. When `wide`=1 the step size is doubled, which gives 2 or 4.
- R4: A stepped index keeps bits [4:3] and replaces bits [2:0] with (bits [2:0] + step) mod 8, so it wraps inside its own bank of eight.
- R5: `out_dst` advances on every element step. In the three-operand form (`three_op`=1), `out_srca` also advances on every step.
- R6: In the three-operand form, `out_srcb` is held at its start value for all elements when that value is in the scalar bank (index mod 32 < 8). Otherwise it advances on every step.
- R7: In the two-operand form (`three_op`=0), `out_srca` advances only when it is outside the scalar bank, and `out_srcb` stays equal to the captured `srcb_in` for every element.
- R8: `out_delayed` is 1 on every element of a run with N >= 2 and is 0 for a run with N = 1.
- R9: A start with N = 1 is legal even when the destination is in the scalar bank, and it produces one element.
- R10: A start with N = 0, N > 8, or N >= 2 with a scalar-bank destination is illegal. In the following cycle it raises `start_err` for one cycle, produces no element and leaves `busy` low.
- R11: While `out_valid`=1 and `out_ready`=0, all stream outputs keep their values.
- R12: A start while `busy`=1 is ignored, except in the cycle in which the final element is transferred. In that case the new run's first element appears in the next cycle with no idle cycle between the runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse for a new run |
| three_op | input | 1 | 1: three-operand form, 0: two-operand form |
| stride_sel | input | 1 | Stride select, 0 gives step 1, 1 gives step 2 |
| wide | input | 1 | Double-width elements, doubles the step |
| vlen | input | 4 | Vector length, legal 1 to 8 |
| dst_in | input | 5 | Starting destination index |
| srca_in | input | 5 | Starting first source index |
| srcb_in | input | 5 | Starting second source index |
| busy | output | 1 | A run is in progress |
| start_err | output | 1 | One-cycle pulse after an illegal start |
| out_valid | output | 1 | Element output is valid |
| out_ready | input | 1 | Consumer accepts the element |
| out_dst | output | 5 | Element destination index |
| out_srca | output | 5 | Element first source index |
| out_srcb | output | 5 | Element second source index |
| out_first | output | 1 | Element is the first of its run |
| out_last | output | 1 | Element is the final one of its run |
| out_delayed | output | 1 | Element is tagged for delayed commit |

## Verification
The risky coincidence is the transfer of a run's final element and the acceptance of a new start on the same clock edge. The bench provokes it by raising `start` together with `out_ready` while the reference model shows that only the final element is left. It also raises `start` at that point with an illegal configuration, so that completion and rejection fall on the same edge. The reference model then expects the new run's first element, or the error pulse with `busy` low, in the very next cycle. Every cycle's outputs are compared against the model, so a lost element, an extra idle cycle or a swallowed start all show up as mismatches.

// File: rtl/svidx_pkg.sv
package svidx_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_EMIT = 1'b1
  } seq_state_t;

  localparam int unsigned NUM_OPS = 3;
  localparam int unsigned OP_DST  = 0;
  localparam int unsigned OP_SRCA = 1;
  localparam int unsigned OP_SRCB = 2;

endpackage

// File: rtl/svidx_scalar_det.sv
module svidx_scalar_det #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned SPAN_W = 5
) (
  input  logic [IDX_W-1:0] idx,
  output logic             is_scalar
);
  localparam int unsigned LOW_W = (IDX_W < SPAN_W) ? IDX_W : SPAN_W;
  localparam logic [LOW_W-1:0] SCALAR_TOP = LOW_W'(1 << BANK_W);

  logic [LOW_W-1:0] low_part;

  generate
    if (IDX_W > LOW_W) begin : g_trunc
      logic [IDX_W-LOW_W-1:0] unused_hi;
      assign unused_hi = idx[IDX_W-1:LOW_W];
      assign low_part  = idx[LOW_W-1:0];
    end else begin : g_full
      assign low_part = idx;
    end
  endgenerate

  assign is_scalar = (low_part < SCALAR_TOP);
endmodule

// File: rtl/svidx_stride.sv
module svidx_stride #(
  parameter int unsigned BANK_W = 3
) (
  input  logic              stride_sel,
  input  logic              wide,
  output logic [BANK_W-1:0] stride
);
  logic [BANK_W-1:0] base;

  always_comb begin
    base   = stride_sel ? BANK_W'(2) : BANK_W'(1);
    stride = wide ? BANK_W'(base << 1) : base;
  end
endmodule

// File: rtl/svidx_stepper.sv
module svidx_stepper #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned BANK_W = 3
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [BANK_W-1:0] stride,
  input  logic              en,
  output logic [IDX_W-1:0]  nxt
);
  logic [BANK_W-1:0] offs;

  always_comb begin
    offs = idx[BANK_W-1:0] + stride;
    nxt  = en ? {idx[IDX_W-1:BANK_W], offs} : idx;
  end
endmodule

// File: rtl/svidx_ctrl.sv
module svidx_ctrl
  import svidx_pkg::*;
#(
  parameter int unsigned MAX_LEN = 8,
  parameter int unsigned LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] vlen,
  input  logic             dst_scalar,
  input  logic             out_ready,
  output logic             busy,
  output logic             out_valid,
  output logic             first,
  output logic             last,
  output logic             delayed,
  output logic             load,
  output logic             adv,
  output logic             start_err
);
  localparam int unsigned CNT_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  seq_state_t       st;
  logic [CNT_W-1:0] elem_idx;
  logic [CNT_W-1:0] len_m1;
  logic             multi;
  logic             err_q;

  logic handoff, done, can_take, take, bad;

  always_comb begin
    handoff  = (st == SEQ_EMIT) && out_ready;
    last     = (elem_idx == len_m1);
    done     = handoff && last;
    can_take = (st == SEQ_IDLE) || done;
    take     = start && can_take;
    bad      = (vlen == '0) || (vlen > LEN_MAX) || ((vlen != LEN_ONE) && dst_scalar);
    load     = take && !bad;
    adv      = handoff && !last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      elem_idx <= '0;
      len_m1   <= '0;
      multi    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      err_q <= take && bad;
      if (load) begin
        st       <= SEQ_EMIT;
        elem_idx <= '0;
        len_m1   <= CNT_W'(vlen - LEN_ONE);
        multi    <= (vlen != LEN_ONE);
      end else if (done) begin
        st <= SEQ_IDLE;
      end else if (adv) begin
        elem_idx <= elem_idx + CNT_W'(1);
      end
    end
  end

  assign busy      = (st == SEQ_EMIT);
  assign out_valid = (st == SEQ_EMIT);
  assign first     = (elem_idx == '0);
  assign delayed   = multi;
  assign start_err = err_q;

  p_rst_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !start_err);

  p_err_no_emit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !busy && !out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(elem_idx) && $stable(delayed));

  p_first_on_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> first);

  p_end_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && last && !start) |=> !out_valid);

  p_single_untagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && first && last) |-> !delayed);
endmodule

// File: rtl/svidx_seq.sv
module svidx_seq
  import svidx_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned BANK_W  = 3,
  parameter int unsigned SPAN_W  = 5,
  parameter int unsigned MAX_LEN = 8,
  parameter int unsigned LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             three_op,
  input  logic             stride_sel,
  input  logic             wide,
  input  logic [LEN_W-1:0] vlen,
  input  logic [IDX_W-1:0] dst_in,
  input  logic [IDX_W-1:0] srca_in,
  input  logic [IDX_W-1:0] srcb_in,
  output logic             busy,
  output logic             start_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [IDX_W-1:0] out_dst,
  output logic [IDX_W-1:0] out_srca,
  output logic [IDX_W-1:0] out_srcb,
  output logic             out_first,
  output logic             out_last,
  output logic             out_delayed
);
  logic [IDX_W-1:0]  in_idx  [NUM_OPS];
  logic [IDX_W-1:0]  cur_idx [NUM_OPS];
  logic [IDX_W-1:0]  nxt_idx [NUM_OPS];
  logic [NUM_OPS-1:0] in_scalar;
  logic [NUM_OPS-1:0] step_en;
  logic [BANK_W-1:0] stride_in;
  logic [BANK_W-1:0] stride_q;
  logic              three_q;
  logic              load, adv;
  logic              cur_b_scalar;

  assign in_idx[OP_DST]  = dst_in;
  assign in_idx[OP_SRCA] = srca_in;
  assign in_idx[OP_SRCB] = srcb_in;

  genvar g;
  generate
    for (g = 0; g < NUM_OPS; g++) begin : g_op
      svidx_scalar_det #(.IDX_W(IDX_W), .BANK_W(BANK_W), .SPAN_W(SPAN_W)) u_det (
        .idx      (in_idx[g]),
        .is_scalar(in_scalar[g])
      );
      svidx_stepper #(.IDX_W(IDX_W), .BANK_W(BANK_W)) u_step (
        .idx   (cur_idx[g]),
        .stride(stride_q),
        .en    (step_en[g]),
        .nxt   (nxt_idx[g])
      );
    end
  endgenerate

  svidx_scalar_det #(.IDX_W(IDX_W), .BANK_W(BANK_W), .SPAN_W(SPAN_W)) u_det_outb (
    .idx      (cur_idx[OP_SRCB]),
    .is_scalar(cur_b_scalar)
  );

  svidx_stride #(.BANK_W(BANK_W)) u_stride (
    .stride_sel(stride_sel),
    .wide      (wide),
    .stride    (stride_in)
  );

  svidx_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .vlen      (vlen),
    .dst_scalar(in_scalar[OP_DST]),
    .out_ready (out_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .first     (out_first),
    .last      (out_last),
    .delayed   (out_delayed),
    .load      (load),
    .adv       (adv),
    .start_err (start_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OPS; i++) cur_idx[i] <= '0;
      step_en  <= '0;
      stride_q <= '0;
      three_q  <= 1'b0;
    end else if (load) begin
      for (int i = 0; i < NUM_OPS; i++) cur_idx[i] <= in_idx[i];
      step_en[OP_DST]  <= 1'b1;
      step_en[OP_SRCA] <= three_op || !in_scalar[OP_SRCA];
      step_en[OP_SRCB] <= three_op && !in_scalar[OP_SRCB];
      stride_q <= stride_in;
      three_q  <= three_op;
    end else if (adv) begin
      for (int i = 0; i < NUM_OPS; i++) cur_idx[i] <= nxt_idx[i];
    end
  end

  assign out_dst  = cur_idx[OP_DST];
  assign out_srca = cur_idx[OP_SRCA];
  assign out_srcb = cur_idx[OP_SRCB];

  logic [BANK_W-1:0] dst_lo_plus;
  assign dst_lo_plus = out_dst[BANK_W-1:0] + stride_q;

  p_bank_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> $stable(out_dst[IDX_W-1:BANK_W])
      && $stable(out_srca[IDX_W-1:BANK_W]) && $stable(out_srcb[IDX_W-1:BANK_W]));

  p_dst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> out_dst[BANK_W-1:0] == $past(dst_lo_plus));

  p_scalar_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last && three_q && cur_b_scalar) |=> $stable(out_srcb));

  p_idx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_dst) && $stable(out_srca) && $stable(out_srcb)
      && $stable(out_first) && $stable(out_last));

  p_stride_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(stride_q) == 1);
endmodule

// File: tb/svidx_seq_test.sv
module svidx_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, three_op = 1'b1, stride_sel = 1'b0, wide = 1'b0;
  logic [3:0] vlen = 4'd1;
  logic [4:0] dst_in = '0, srca_in = '0, srcb_in = '0;
  logic out_ready = 1'b1;
  logic busy, start_err, out_valid, out_first, out_last, out_delayed;
  logic [4:0] out_dst, out_srca, out_srcb;

  always #(CLK_PERIOD/2) clk = ~clk;

  svidx_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .three_op(three_op),
    .stride_sel(stride_sel), .wide(wide), .vlen(vlen),
    .dst_in(dst_in), .srca_in(srca_in), .srcb_in(srcb_in),
    .busy(busy), .start_err(start_err), .out_valid(out_valid), .out_ready(out_ready),
    .out_dst(out_dst), .out_srca(out_srca), .out_srcb(out_srcb),
    .out_first(out_first), .out_last(out_last), .out_delayed(out_delayed)
  );

  typedef struct packed {
    logic [4:0] d, a, b;
    logic first, last, dly;
  } elem_t;

  elem_t q[$];
  logic  err_exp = 1'b0;
  int    checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit    rnd_ready = 0;
  bit    done_flag = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  function automatic logic is_sc(logic [4:0] x);
    return (int'(x) % 32) < 8;
  endfunction

  function automatic logic [4:0] at_k(logic [4:0] base, int step, int k);
    return 5'((int'(base) / 8) * 8 + ((int'(base) % 8) + k * step) % 8);
  endfunction

  // Reference model: applies the inputs held over the edge just passed.
  task automatic model_step();
    bit pop, can, legal;
    int step, n;
    if (!rst_n) begin
      q.delete();
      err_exp = 1'b0;
      return;
    end
    pop = (q.size() > 0) && out_ready;
    can = (q.size() == 0) || (pop && q.size() == 1);
    if (pop) void'(q.pop_front());
    n = int'(vlen);
    legal = (n >= 1) && (n <= 8) && !(n >= 2 && is_sc(dst_in));
    err_exp = start && can && !legal;
    if (start && can && legal) begin
      step = (stride_sel ? 2 : 1) * (wide ? 2 : 1);
      for (int k = 0; k < n; k++) begin
        elem_t e;
        e.d = at_k(dst_in, step, k);
        e.a = (three_op || !is_sc(srca_in)) ? at_k(srca_in, step, k) : srca_in;
        e.b = (three_op && !is_sc(srcb_in)) ? at_k(srcb_in, step, k) : srcb_in;
        e.first = (k == 0);
        e.last  = (k == n - 1);
        e.dly   = (n >= 2);
        q.push_back(e);
      end
    end
  endtask

  task automatic compare();
    chk("out_valid", int'(out_valid), int'(q.size() > 0));
    chk("busy", int'(busy), int'(q.size() > 0));
    chk("start_err", int'(start_err), int'(err_exp));
    if (q.size() > 0 && out_valid) begin
      chk("out_dst", int'(out_dst), int'(q[0].d));
      chk("out_srca", int'(out_srca), int'(q[0].a));
      chk("out_srcb", int'(out_srcb), int'(q[0].b));
      chk("out_first", int'(out_first), int'(q[0].first));
      chk("out_last", int'(out_last), int'(q[0].last));
      chk("out_delayed", int'(out_delayed), int'(q[0].dly));
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    compare();
    out_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
  endtask

  task automatic launch(bit t3, bit ss, bit wd, int n, int d, int a, int b);
    three_op = t3; stride_sel = ss; wide = wd; vlen = 4'(n);
    dst_in = 5'(d); srca_in = 5'(a); srcb_in = 5'(b);
    start = 1'b1;
    tick();
    start = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() > 0 && guard < 200) begin tick(); guard++; end
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    cur_req = "R1";
    chk("reset busy", int'(busy), 0);
    chk("reset out_valid", int'(out_valid), 0);
    chk("reset start_err", int'(start_err), 0);
    rst_n = 1'b1;
    tick();

    cur_req = "R2"; launch(1, 0, 0, 4, 8, 16, 24);  drain();
    cur_req = "R5"; launch(1, 0, 0, 8, 9, 17, 25);  drain();
    cur_req = "R3"; launch(1, 1, 0, 4, 8, 16, 24);  drain();
    cur_req = "R3"; launch(1, 0, 1, 4, 10, 18, 26); drain();
    cur_req = "R3"; launch(1, 1, 1, 3, 12, 20, 28); drain();
    cur_req = "R4"; launch(1, 1, 1, 4, 14, 31, 23); drain();
    cur_req = "R6"; launch(1, 0, 0, 5, 8, 16, 3);   drain();
    cur_req = "R6"; launch(1, 1, 0, 5, 8, 16, 27);  drain();
    cur_req = "R7"; launch(0, 0, 0, 4, 8, 5, 19);   drain();
    cur_req = "R7"; launch(0, 1, 0, 4, 8, 20, 2);   drain();
    cur_req = "R8"; launch(1, 0, 0, 1, 8, 16, 24);  drain();
    cur_req = "R9"; launch(1, 0, 0, 1, 2, 3, 4);    drain();
    cur_req = "R10"; launch(1, 0, 0, 3, 4, 16, 24); drain();
    cur_req = "R10"; launch(1, 0, 0, 0, 8, 16, 24); drain();
    cur_req = "R10"; launch(1, 0, 0, 9, 8, 16, 24); drain();

    // R11: stall under back-pressure
    cur_req = "R11";
    out_ready = 1'b0;
    three_op = 1; stride_sel = 0; wide = 0; vlen = 4'd4;
    dst_in = 5'd13; srca_in = 5'd21; srcb_in = 5'd29; start = 1'b1;
    @(negedge clk); model_step(); compare(); start = 1'b0; out_ready = 1'b0;
    repeat (4) begin @(negedge clk); model_step(); compare(); out_ready = 1'b0; end
    drain();

    // R12: start while busy is ignored
    cur_req = "R12";
    launch(1, 0, 0, 4, 8, 16, 24);
    start = 1'b1; vlen = 4'd2; dst_in = 5'd30;
    tick(); start = 1'b0;
    drain();

    // R12: start coinciding with the final transfer, no gap
    launch(1, 0, 0, 3, 8, 16, 24);
    while (q.size() > 1) tick();
    out_ready = 1'b1; start = 1'b1;
    three_op = 1; stride_sel = 1; vlen = 4'd2; dst_in = 5'd22; srca_in = 5'd6; srcb_in = 5'd7;
    tick(); start = 1'b0;
    chk("no gap valid", int'(out_valid), 1);
    chk("no gap first", int'(out_first), 1);
    chk("no gap dst", int'(out_dst), 22);
    drain();

    // R10 with R12: illegal start on the final transfer
    launch(1, 0, 0, 2, 8, 16, 24);
    while (q.size() > 1) tick();
    out_ready = 1'b1; start = 1'b1; vlen = 4'd5; dst_in = 5'd1;
    tick(); start = 1'b0;
    chk("collide err", int'(start_err), 1);
    chk("collide busy", int'(busy), 0);
    drain();

    // R11: random traffic with random back-pressure
    cur_req = "R11";
    rnd_ready = 1;
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 3 == 0) begin
        start = 1'b1;
        three_op = 1'($urandom); stride_sel = 1'($urandom); wide = 1'($urandom);
        vlen = 4'($urandom % 10);
        dst_in = 5'($urandom); srca_in = 5'($urandom); srcb_in = 5'($urandom);
      end else start = 1'b0;
      tick();
    end
    start = 1'b0; rnd_ready = 0;
    drain();

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog %s actual %0d expected %0d", cur_req, cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule